// File: doc/BRIEF.md
# Reset Cause Register with Software Reset Requests

This block keeps a single 32-bit register that tells software why the chip last came out of reset and lets software ask for a new reset. Five flags in the top bits of the word carry this information. The first system reset after power-up, or after software has re-armed the detector, loads the word with only the power-on flag set. Button events set their own flags. Software clears a cause flag by writing a one to it.

Two further flags are plain read/write. Setting the soft power-on flag asks for a system reset and re-arms the first-reset detector, so the next system reset reports a power-on again. Setting the soft externally-initiated flag asks for a reset without re-arming. Either request comes out as a single-cycle pulse on `rst_req_o`, one clock after the write. The register is the upper word of an 8-byte window at byte offset 0xF020 of a 16-bit register port. Reads are combinational on the address.

Two resets are kept apart. `rst_n` is the power-up reset: it clears the register and arms the detector. `sys_rst_i` is a one-cycle system reset event, and the armed state survives it.

Top module: `rst_status_ctrl`

## Requirements
- R1: After `rst_n` is released, the register at 0xF024 reads 0x00000000 and `rst_req_o` is low.
- R2: A `sys_rst_i` pulse while the detector is armed loads the register with exactly 0x80000000 and disarms the detector. A `sys_rst_i` pulse while disarmed leaves the register unchanged.
- R3: Bits 31, 28 and 27 are write-one-to-clear. Writing 1 to one of these bits clears it; writing 0 leaves it unchanged.
- R4: Bits 30 and 29 take the written value directly, whether that value is 1 or 0.
- R5: Bits 26:0 always read as zero, whatever was written.
- R6: The rest of the 0xF020–0xF027 window and all addresses outside it behave as follows:
  - The lower word (0xF020) reads zero and ignores writes.
  - Addresses outside the window read zero and ignore writes.
  - None of these writes causes a request.
- R7: A write to 0xF024 with bit 30 set produces a request pulse on the next cycle and re-arms the detector. The next `sys_rst_i` then loads 0x80000000.
- R8: A write with bit 29 set and bit 30 clear produces a request pulse on the next cycle and does not re-arm the detector.
- R9: `btn_por_i` sets bit 28 and `btn_xir_i` sets bit 27. A button set wins over a write clearing the same bit in the same cycle.
- R10: `rst_req_o` is high for exactly one cycle per accepting write, and only after a write whose masked data has bit 30 or bit 29 set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-up reset |
| sys_rst_i | input | 1 | One-cycle system reset event |
| btn_por_i | input | 1 | Button power-on reset event |
| btn_xir_i | input | 1 | Button externally-initiated reset event |
| reg_addr | input | 16 | Register port byte address |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| rst_req_o | output | 1 | One-cycle system reset request |

## Verification
The assertions assume the following about the inputs:
- `sys_rst_i` is a synchronous one-cycle event.
- A system reset arriving in the same cycle as a write takes precedence over that write, so the write-related properties exclude cycles with `sys_rst_i` high.
- Input values before `rst_n` is released are not sampled.

The stimulus drives every input on the falling edge and never raises `sys_rst_i` during a write. Every button pulse and every write lasts exactly one cycle, which keeps the pulse-width and cause properties within their stated preconditions.

// File: rtl/rsc_pkg.sv
package rsc_pkg;
  localparam int REG_W = 32;

  // Flag positions: the detector and request logic depend on these.
  localparam int POS_PWR   = 31;
  localparam int POS_SPWR  = 30;
  localparam int POS_SEXT  = 29;
  localparam int POS_BPWR  = 28;
  localparam int POS_BEXT  = 27;

  localparam logic [REG_W-1:0] LIVE_MASK  = 32'hF800_0000;
  localparam logic [REG_W-1:0] CLR1_MASK  = 32'h9800_0000;
  localparam logic [REG_W-1:0] PLAIN_MASK = 32'h6000_0000;
  localparam logic [REG_W-1:0] PWR_WORD   = 32'h8000_0000;
endpackage

// File: rtl/rsc_decode.sv
module rsc_decode #(
  parameter int                ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] WIN_BASE = 16'hF020
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hi_hit
);
  localparam int WORD_BIT = 2;
  localparam int WIN_LSB  = 3;

  logic in_win;
  logic unused_low;

  assign in_win     = (addr[ADDR_W-1:WIN_LSB] == WIN_BASE[ADDR_W-1:WIN_LSB]);
  assign hi_hit     = in_win & addr[WORD_BIT];
  assign unused_low = ^addr[WORD_BIT-1:0];
endmodule

// File: rtl/rsc_status_reg.sv
module rsc_status_reg
  import rsc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wdata,
  input  logic             sys_rst,
  input  logic             btn_pwr,
  input  logic             btn_ext,
  output logic [REG_W-1:0] stat_q
);
  logic [REG_W-1:0] wd_m;
  logic [REG_W-1:0] hw_set;
  logic [REG_W-1:0] upd;
  logic [REG_W-1:0] stat_d;
  logic             stat_en;
  logic             armed_q, armed_d, armed_en;
  logic             rearm, first_load;
  logic             unused_wd;

  assign wd_m      = wdata & LIVE_MASK;
  assign unused_wd = ^(wdata & ~LIVE_MASK);

  always_comb begin
    hw_set           = '0;
    hw_set[POS_BPWR] = btn_pwr;
    hw_set[POS_BEXT] = btn_ext;
  end

  // Per-bit update rule selected from the masks.
  for (genvar i = 0; i < REG_W; i++) begin : g_bit
    if (CLR1_MASK[i]) begin : g_clr1
      assign upd[i] = hw_set[i] | (stat_q[i] & ~(wr_en & wd_m[i]));
    end else if (PLAIN_MASK[i]) begin : g_plain
      assign upd[i] = wr_en ? wd_m[i] : stat_q[i];
    end else begin : g_zero
      assign upd[i] = 1'b0;
    end
  end

  assign rearm      = wr_en & wd_m[POS_SPWR];
  assign first_load = sys_rst & armed_q;

  always_comb begin
    stat_d  = first_load ? PWR_WORD : upd;
    stat_en = wr_en | sys_rst | btn_pwr | btn_ext;
  end

  always_comb begin
    armed_d = armed_q;
    if (first_load) armed_d = 1'b0;
    if (rearm)      armed_d = 1'b1;
    armed_en = first_load | rearm;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q  <= '0;
      armed_q <= 1'b1;
    end else begin
      if (stat_en)  stat_q  <= stat_d;
      if (armed_en) armed_q <= armed_d;
    end
  end
endmodule

// File: rtl/rsc_req_gen.sv
module rsc_req_gen
  import rsc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wdata,
  output logic             req_o
);
  logic fire;
  logic req_q;

  assign fire  = wr_en & (wdata[POS_SPWR] | wdata[POS_SEXT]);
  assign req_o = req_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= fire;
  end
endmodule

// File: rtl/rst_status_ctrl.sv
module rst_status_ctrl
  import rsc_pkg::*;
#(
  parameter int                ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] WIN_BASE = 16'hF020
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sys_rst_i,
  input  logic              btn_por_i,
  input  logic              btn_xir_i,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              rst_req_o
);
  logic             hi_hit;
  logic             wr_hi;
  logic [REG_W-1:0] stat_q;

  rsc_decode #(.ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE)) u_dec (
    .addr   (reg_addr),
    .hi_hit (hi_hit)
  );

  assign wr_hi = reg_we & hi_hit;

  rsc_status_reg u_stat (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_hi),
    .wdata   (reg_wdata),
    .sys_rst (sys_rst_i),
    .btn_pwr (btn_por_i),
    .btn_ext (btn_xir_i),
    .stat_q  (stat_q)
  );

  rsc_req_gen u_req (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_hi),
    .wdata (reg_wdata),
    .req_o (rst_req_o)
  );

  assign reg_rdata = hi_hit ? stat_q : '0;
endmodule

// File: rtl/rst_status_ctrl_chk.sv
module rst_status_ctrl_chk
  import rsc_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             wr_hi,
  input logic [REG_W-1:0] wdata,
  input logic             sys_rst_i,
  input logic             btn_por_i,
  input logic [REG_W-1:0] stat_q,
  input logic             rst_req_o
);
  assert_clr_pwr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hi && wdata[POS_PWR] && !sys_rst_i) |=> !stat_q[POS_PWR]);

  assert_plain_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hi && !sys_rst_i) |=> (stat_q[POS_SPWR:POS_SEXT] == $past(wdata[POS_SPWR:POS_SEXT])));

  assert_soft_pwr_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hi && wdata[POS_SPWR]) |=> rst_req_o);

  assert_soft_ext_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hi && wdata[POS_SEXT] && !wdata[POS_SPWR]) |=> rst_req_o);

  assert_btn_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (btn_por_i && !sys_rst_i) |=> stat_q[POS_BPWR]);

  assert_req_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |-> $past(wr_hi && (wdata[POS_SPWR] || wdata[POS_SEXT])));
endmodule

bind rst_status_ctrl rst_status_ctrl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_hi     (wr_hi),
  .wdata     (reg_wdata),
  .sys_rst_i (sys_rst_i),
  .btn_por_i (btn_por_i),
  .stat_q    (stat_q),
  .rst_req_o (rst_req_o)
);

// File: tb/rst_status_ctrl_test.sv
module rst_status_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] A_HI = 16'hF024;
  localparam logic [15:0] A_LO = 16'hF020;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sys_rst_i = 1'b0;
  logic        btn_por_i = 1'b0;
  logic        btn_xir_i = 1'b0;
  logic [15:0] reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        rst_req_o;

  int checks = 0;
  int fails  = 0;
  int pulse_cnt = 0;
  int run_len = 0;
  int max_run = 0;
  bit done = 0;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb_q[$];
  event  smp_ev;

  rst_status_ctrl uut (
    .clk(clk), .rst_n(rst_n), .sys_rst_i(sys_rst_i), .btn_por_i(btn_por_i),
    .btn_xir_i(btn_xir_i), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rst_req_o(rst_req_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Pulse monitor, sampled on the falling edge.
  always @(negedge clk) begin
    if (rst_n) begin
      if (rst_req_o === 1'b1) begin
        pulse_cnt++;
        run_len++;
        if (run_len > max_run) max_run = run_len;
      end else begin
        run_len = 0;
      end
    end
  end

  // Scoreboard monitor.
  initial begin
    forever begin
      @(smp_ev);
      while (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        checks++;
        if (reg_rdata !== it.exp) begin
          fails++;
          $display("FAIL %s: rdata actual %h expected %h", it.tag, reg_rdata, it.exp);
        end
      end
    end
  end

  task automatic rd(input logic [15:0] a, input logic [31:0] e, input string tag);
    item_t it;
    @(negedge clk);
    reg_addr = a;
    #1;
    it.exp = e;
    it.tag = tag;
    sb_q.push_back(it);
    -> smp_ev;
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d, input bit ext = 1'b0);
    @(negedge clk);
    reg_addr  = a;
    reg_wdata = d;
    reg_we    = 1'b1;
    btn_xir_i = ext;
    @(negedge clk);
    reg_we    = 1'b0;
    btn_xir_i = 1'b0;
  endtask

  task automatic sysrst();
    @(negedge clk);
    sys_rst_i = 1'b1;
    @(negedge clk);
    sys_rst_i = 1'b0;
  endtask

  task automatic btn(input bit pwr);
    @(negedge clk);
    if (pwr) btn_por_i = 1'b1; else btn_xir_i = 1'b1;
    @(negedge clk);
    btn_por_i = 1'b0;
    btn_xir_i = 1'b0;
  endtask

  task automatic chk_int(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic chk_pulses(input int exp, input string tag);
    @(negedge clk);
    chk_int(pulse_cnt, exp, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    rd(A_HI, 32'h0, "R1");
    chk_int(rst_req_o, 0, "R1 req low");

    // R2: first system reset loads power-on word
    sysrst();
    rd(A_HI, 32'h8000_0000, "R2 first load");

    // R3: clear power-on flag by writing one
    wr(A_HI, 32'h8000_0000);
    rd(A_HI, 32'h0, "R3 clear bit31");

    // R9: buttons set their flags
    btn(1'b1);
    rd(A_HI, 32'h1000_0000, "R9 btn pwr");
    btn(1'b0);
    rd(A_HI, 32'h1800_0000, "R9 btn ext");

    // R3: one clears bit 27, zero keeps bit 28
    wr(A_HI, 32'h0800_0000);
    rd(A_HI, 32'h1000_0000, "R3 selective clear");

    // R2: disarmed system reset leaves word alone
    sysrst();
    rd(A_HI, 32'h1000_0000, "R2 later reset unchanged");

    // R8: soft external request, no re-arm
    wr(A_HI, 32'h2000_0000);
    chk_pulses(1, "R8 pulse");
    rd(A_HI, 32'h3000_0000, "R4 bit29 set");
    sysrst();
    rd(A_HI, 32'h3000_0000, "R8 no rearm");

    // R4: plain bits take written zero
    wr(A_HI, 32'h0000_0000);
    rd(A_HI, 32'h1000_0000, "R4 bit29 cleared");

    // R5: low bits never stick
    wr(A_HI, 32'h07FF_FFFF);
    rd(A_HI, 32'h1000_0000, "R5 low bits zero");

    // R6: lower word and outside addresses
    wr(A_LO, 32'hFFFF_FFFF);
    rd(A_HI, 32'h1000_0000, "R6 lower word write ignored");
    rd(A_LO, 32'h0, "R6 lower word reads zero");
    wr(16'hF02C, 32'hFFFF_FFFF);
    wr(16'h2000, 32'hFFFF_FFFF);
    rd(A_HI, 32'h1000_0000, "R6 outside write ignored");
    rd(16'h2000, 32'h0, "R6 outside reads zero");
    chk_pulses(1, "R6 no request");

    // R9: button set beats same-cycle clear
    wr(A_HI, 32'h0800_0000, 1'b1);
    rd(A_HI, 32'h1800_0000, "R9 set wins");
    wr(A_HI, 32'h1000_0000);
    rd(A_HI, 32'h0800_0000, "R3 clear bit28");

    // R7: soft power-on request re-arms
    wr(A_HI, 32'h4000_0000);
    chk_pulses(2, "R7 pulse");
    rd(A_HI, 32'h4800_0000, "R4 bit30 set");
    sysrst();
    rd(A_HI, 32'h8000_0000, "R7 rearmed load");
    sysrst();
    rd(A_HI, 32'h8000_0000, "R2 second reset unchanged");
    wr(A_HI, 32'h8000_0000);
    sysrst();
    rd(A_HI, 32'h0, "R2 disarmed after load");

    // R10: both soft bits give one single-cycle pulse
    wr(A_HI, 32'h6000_0000);
    chk_pulses(3, "R10 one pulse");
    chk_int(max_run, 1, "R10 width");
    rd(A_HI, 32'h6000_0000, "R4 both plain set");

    done = 1;
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule